// File: doc/BRIEF.md
# Message Buffer Interrupt Flag Unit

This unit keeps the per-buffer interrupt state for a sixteen-buffer message controller. A completion pulse arrives on one input line per buffer whenever that buffer finishes a successful transmit or receive. Each pulse latches the buffer's pending flag. A per-buffer enable bit decides whether a pending flag contributes to the single interrupt request sent to the processor.

Software reaches both registers over a small synchronous register bus. It can access each register as a full 16-bit word or as either byte lane. Pending flags cannot be set by software.

Clearing a flag is guarded against races. A read that returns one for a bit arms that bit, and a later zero written to the bit clears it. A completion for the buffer between that read and that write disarms the bit, so the zero write leaves the new event pending.

Top module: `msg_irq_unit`

## Requirements
- R1: After reset, the enable register and the pending register are all zeros, irq_o is 0 and rdata_o is 0.
- R2: A write with sel_i=0 updates the enable register. be_i[0] selects bits 7:0 and be_i[1] selects bits 15:8. A lane whose enable is low keeps its old value.
- R3: A one on evt_i[k] in a cycle sets pending bit k at that clock edge.
- R4: Writing ones to the pending register (sel_i=1) never sets a pending bit.
- R5: A zero written to a pending bit that has not been read as one since its last write or event leaves the bit set.
- R6: A read with sel_i=1 arms every pending bit that is one in the enabled byte lanes. A later zero written to an armed bit clears it. Bits in lanes that were not read are not armed.
- R7: A completion event on a bit after it was read as one, and before the zero write, keeps the bit set through that write.
- R8: When a completion event and a clearing write reach the same bit in the same cycle, the bit stays set.
- R9: irq_o is a level equal to the OR over all buffers of pending AND enable, taken from the register values one clock edge earlier.
- R10: rdata_o holds the selected register (sel_i=0 enable, sel_i=1 pending) in the cycle after a read strobe. Lanes whose byte enable was low return zero. rdata_o is zero in any cycle that does not follow a read.
- R11: Any write that covers a pending bit disarms that bit, including a write of one. A later zero write without a new read then leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 16 | Per-buffer completion pulses |
| sel_i | input | 1 | Register select: 0 enable, 1 pending |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| be_i | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after rd_i |
| irq_o | output | 1 | Level interrupt request |

## Verification
The clearing path is tried with several sequences:

- A bare zero write.
- A read followed by a zero write.
- A partial-lane read followed by a full zero write.
- A read, then an event, then a zero write.
- A zero write in the same cycle as an event.
- A read, then a write of ones, then a zero write.

Each of these differs from the others only in whether the arm survives, so each tells a distinct arm rule apart. Word, low-byte and high-byte writes to the enable register, together with partial reads, show that the lanes are independent.

The interrupt output is observed with an unmasked event, then a masked event, then a flag clear and a mask clear. Together these confirm the AND, the OR and the one-cycle latency.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;
  localparam int unsigned LANE_W = 8;
  typedef enum logic {SEL_MASK = 1'b0, SEL_FLAG = 1'b1} reg_sel_e;
endpackage

// File: rtl/mif_lane_decode.sv
module mif_lane_decode
  import msg_irq_pkg::*;
#(
  parameter int unsigned NBUF  = 16,
  localparam int unsigned LANES = NBUF / LANE_W
) (
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             sel_i,
  input  logic [LANES-1:0] be_i,
  output logic [NBUF-1:0]  rd_flag_o,
  output logic [NBUF-1:0]  wr_flag_o,
  output logic [NBUF-1:0]  wr_mask_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(sel_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rd_flag_o[l*LANE_W +: LANE_W] = {LANE_W{rd_i & be_i[l] & (sel == SEL_FLAG)}};
    assign wr_flag_o[l*LANE_W +: LANE_W] = {LANE_W{wr_i & be_i[l] & (sel == SEL_FLAG)}};
    assign wr_mask_o[l*LANE_W +: LANE_W] = {LANE_W{wr_i & be_i[l] & (sel == SEL_MASK)}};
  end
endmodule

// File: rtl/mif_flag_cell.sv
module mif_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic rd_hit_i,
  input  logic wr_hit_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, arm_q;

  // event beats any write; write beats read for arming
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (evt_i) begin
      flag_q <= 1'b1;
      arm_q  <= 1'b0;
    end else if (wr_hit_i) begin
      if (arm_q && !wbit_i) flag_q <= 1'b0;
      arm_q <= 1'b0;
    end else if (rd_hit_i && flag_q) begin
      arm_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/mif_mask_reg.sv
module mif_mask_reg
  import msg_irq_pkg::*;
#(
  parameter int unsigned NBUF  = 16,
  localparam int unsigned LANES = NBUF / LANE_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NBUF-1:0] wr_en_i,
  input  logic [NBUF-1:0] wdata_i,
  output logic [NBUF-1:0] mask_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 lane_q <= '0;
      else if (wr_en_i[l*LANE_W])  lane_q <= wdata_i[l*LANE_W +: LANE_W];
    end
    assign mask_o[l*LANE_W +: LANE_W] = lane_q;
  end
endmodule

// File: rtl/mif_rd_port.sv
module mif_rd_port
  import msg_irq_pkg::*;
#(
  parameter int unsigned NBUF  = 16,
  localparam int unsigned LANES = NBUF / LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             sel_i,
  input  logic [LANES-1:0] be_i,
  input  logic [NBUF-1:0]  flag_i,
  input  logic [NBUF-1:0]  mask_i,
  output logic [NBUF-1:0]  rdata_o
);
  logic [NBUF-1:0] lane_en, src, rdata_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_en[l*LANE_W +: LANE_W] = {LANE_W{be_i[l]}};
  end

  assign src = (reg_sel_e'(sel_i) == SEL_FLAG) ? flag_i : mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= src & lane_en;
    else           rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/mif_irq_out.sv
module mif_irq_out #(
  parameter int unsigned NBUF = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NBUF-1:0] flag_i,
  input  logic [NBUF-1:0] mask_i,
  output logic            irq_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flag_i & mask_i);
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/msg_irq_unit.sv
module msg_irq_unit
  import msg_irq_pkg::*;
#(
  parameter int unsigned NBUF  = 16,
  localparam int unsigned LANES = NBUF / LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NBUF-1:0]  evt_i,
  input  logic             sel_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [LANES-1:0] be_i,
  input  logic [NBUF-1:0]  wdata_i,
  output logic [NBUF-1:0]  rdata_o,
  output logic             irq_o
);
  logic [NBUF-1:0] rd_flag, wr_flag, wr_mask;
  logic [NBUF-1:0] flag_q, mask_q;

  mif_lane_decode #(.NBUF(NBUF)) u_dec (
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .sel_i    (sel_i),
    .be_i     (be_i),
    .rd_flag_o(rd_flag),
    .wr_flag_o(wr_flag),
    .wr_mask_o(wr_mask)
  );

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    mif_flag_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt_i[b]),
      .rd_hit_i(rd_flag[b]),
      .wr_hit_i(wr_flag[b]),
      .wbit_i  (wdata_i[b]),
      .flag_o  (flag_q[b])
    );
  end

  mif_mask_reg #(.NBUF(NBUF)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_mask),
    .wdata_i(wdata_i),
    .mask_o (mask_q)
  );

  mif_rd_port #(.NBUF(NBUF)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_i),
    .sel_i  (sel_i),
    .be_i   (be_i),
    .flag_i (flag_q),
    .mask_i (mask_q),
    .rdata_o(rdata_o)
  );

  mif_irq_out #(.NBUF(NBUF)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .flag_i(flag_q),
    .mask_i(mask_q),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/msg_irq_chk.sv
module msg_irq_chk #(
  parameter int unsigned NBUF = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NBUF-1:0] evt_i,
  input logic            sel_i,
  input logic            rd_i,
  input logic            wr_i,
  input logic [NBUF-1:0] rdata_o,
  input logic            irq_o,
  input logic [NBUF-1:0] flag_q,
  input logic [NBUF-1:0] mask_q
);
  AST_EVT_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));  // R3

  AST_NO_SW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == '0) |=> ((flag_q & ~$past(flag_q)) == '0));  // R4

  AST_FALL_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(flag_q) & ~flag_q) != '0) |-> $past(wr_i && sel_i));  // R5

  AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0));  // R10

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && !sel_i) |=> $stable(mask_q));  // R2

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(mask_q) != '0));  // R9

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(flag_q) != '0));  // R9
endmodule

bind msg_irq_unit msg_irq_chk #(.NBUF(NBUF)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .evt_i  (evt_i),
  .sel_i  (sel_i),
  .rd_i   (rd_i),
  .wr_i   (wr_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .flag_q (flag_q),
  .mask_q (mask_q)
);

// File: tb/tb_msg_irq_unit.sv
`timescale 1ns/1ps
module tb_msg_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic        sel = 1'b0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  be = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  msg_irq_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .sel_i(sel), .rd_i(rd),
    .wr_i(wr), .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic s, input logic [1:0] b, input logic [15:0] d);
    @(negedge clk); sel = s; be = b; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; be = '0;
  endtask

  task automatic bus_rd(input logic s, input logic [1:0] b, output logic [15:0] d);
    @(negedge clk); sel = s; be = b; rd = 1'b1;
    @(negedge clk); rd = 1'b0; be = '0; d = rdata;
  endtask

  task automatic pulse(input logic [15:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  task automatic clear_all();
    logic [15:0] d;
    bus_rd(1'b1, 2'b11, d);
    bus_wr(1'b1, 2'b11, 16'h0000);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 rdata", rdata, 16'h0);
    bus_rd(1'b0, 2'b11, d); chk("R1 mask", d, 16'h0);
    bus_rd(1'b1, 2'b11, d); chk("R1 flag", d, 16'h0);
    @(negedge clk); chk("R10 idle zero", rdata, 16'h0);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    bus_wr(1'b0, 2'b11, 16'hA5C3);
    bus_rd(1'b0, 2'b11, d); chk("R2 word", d, 16'hA5C3);
    bus_wr(1'b0, 2'b01, 16'hFF11);
    bus_rd(1'b0, 2'b11, d); chk("R2 low", d, 16'hA511);
    bus_wr(1'b0, 2'b10, 16'h7700);
    bus_rd(1'b0, 2'b11, d); chk("R2 high", d, 16'h7711);
    bus_rd(1'b0, 2'b01, d); chk("R10 low lane only", d, 16'h0011);
    bus_rd(1'b0, 2'b10, d); chk("R10 high lane only", d, 16'h7700);
    bus_wr(1'b0, 2'b11, 16'h0000);
  endtask

  task automatic t_set_and_sw();
    logic [15:0] d;
    pulse(16'h8001);
    bus_wr(1'b1, 2'b11, 16'hFFFF);
    bus_rd(1'b1, 2'b11, d); chk("R3 R4 set by event only", d, 16'h8001);
    clear_all();
    bus_rd(1'b1, 2'b11, d); chk("R6 full clear", d, 16'h0000);
  endtask

  task automatic t_no_arm();
    logic [15:0] d;
    pulse(16'h0004);
    bus_wr(1'b1, 2'b11, 16'h0000);
    bus_rd(1'b1, 2'b11, d); chk("R5 unarmed zero write", d, 16'h0004);
    bus_wr(1'b1, 2'b11, 16'h0000);
    bus_rd(1'b1, 2'b11, d); chk("R6 armed clear", d, 16'h0000);
  endtask

  task automatic t_lane_arm();
    logic [15:0] d;
    pulse(16'h0101);
    bus_rd(1'b1, 2'b01, d); chk("R6 low read data", d, 16'h0001);
    bus_wr(1'b1, 2'b11, 16'h0000);
    bus_rd(1'b1, 2'b11, d); chk("R6 unread lane kept", d, 16'h0100);
    bus_wr(1'b1, 2'b11, 16'h0000);
  endtask

  task automatic t_race();
    logic [15:0] d;
    pulse(16'h0010);
    bus_rd(1'b1, 2'b11, d);
    pulse(16'h0010);
    bus_wr(1'b1, 2'b11, 16'h0000);
    bus_rd(1'b1, 2'b11, d); chk("R7 event between read and write", d, 16'h0010);
    bus_wr(1'b1, 2'b11, 16'h0000);
    bus_rd(1'b1, 2'b11, d); chk("R7 later clear", d, 16'h0000);
  endtask

  task automatic t_same_cycle();
    logic [15:0] d;
    pulse(16'h0020);
    bus_rd(1'b1, 2'b11, d);
    @(negedge clk); sel = 1'b1; be = 2'b11; wdata = 16'h0000; wr = 1'b1; evt = 16'h0020;
    @(negedge clk); wr = 1'b0; be = '0; evt = '0;
    bus_rd(1'b1, 2'b11, d); chk("R8 event wins", d, 16'h0020);
    bus_wr(1'b1, 2'b11, 16'h0000);
  endtask

  task automatic t_write_one_disarms();
    logic [15:0] d;
    pulse(16'h0040);
    bus_rd(1'b1, 2'b11, d);
    bus_wr(1'b1, 2'b11, 16'hFFFF);
    bus_wr(1'b1, 2'b11, 16'h0000);
    bus_rd(1'b1, 2'b11, d); chk("R11 one write disarms", d, 16'h0040);
    clear_all();
  endtask

  task automatic t_irq();
    bus_wr(1'b0, 2'b11, 16'h0002);
    pulse(16'h0004);
    @(negedge clk); chk("R9 masked event", {15'b0, irq}, 16'h0);
    pulse(16'h0002);
    chk("R9 latency", {15'b0, irq}, 16'h0);
    @(negedge clk); chk("R9 request", {15'b0, irq}, 16'h1);
    bus_wr(1'b0, 2'b11, 16'h0000);
    chk("R9 mask drop latency", {15'b0, irq}, 16'h1);
    @(negedge clk); chk("R9 mask drop", {15'b0, irq}, 16'h0);
    bus_wr(1'b0, 2'b11, 16'h0002);
    @(negedge clk); chk("R9 mask restore", {15'b0, irq}, 16'h1);
    clear_all();
    @(negedge clk); chk("R9 flag clear", {15'b0, irq}, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mask();
    t_set_and_sw();
    t_no_arm();
    t_lane_arm();
    t_race();
    t_same_cycle();
    t_write_one_disarms();
    t_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule